// File: doc/BRIEF.md
# Quadrature Position Counter with Capture and Wrap Flags

This block turns the two phase-shifted track signals of an incremental encoder into a 16-bit unsigned position. It counts one step on every level change of either track, so a full signal cycle is four counts. It counts up when track A leads track B and down when B leads A. A gate input freezes the count. Software can load the counter with a preset word. Two single-shot capture sources, an external strobe and the encoder's once-per-revolution reference pulse, copy the live count into a shared capture register.

An 8-bit control byte selects the behaviour and an 8-bit status byte reports it. Two wrap flags record whether the last wrap of the range went upward or downward. Each flag clears itself with hysteresis: when the count moves well away from the wrap point, or when a wrap in the opposite direction occurs. All inputs are assumed to be synchronous to `clk` already.

Top module: `qenc_position_unit`

## Requirements
- R1: The tracks, read as (A,B), are sampled each clock. A change along 00→10→11→01→00 adds one to the count, and a change along the reverse sequence subtracts one. The count is visible one clock after the sample that shows the change.
- R2: A sample in which both A and B differ from the previous sample leaves the count unchanged.
- R3: While `gate_in` is high, track changes do not alter the count. When `gate_in` is low, counting proceeds.
- R4: The count is 16 bits unsigned and wraps from 65535 to 0 on an up step, and from 0 to 65535 on a down step.
- R5: A rising edge of control bit 2 loads `preset_val` into the count. Holding bit 2 high loads nothing further. Status bit 2 (set acknowledge) rises with the load and falls once control bit 2 is low.
- R6: Status bit 4 (overflow) sets on an up step from 65535. It clears on an up step from 21845 to 21846, or when an underflow occurs.
- R7: Status bit 3 (underflow) sets on a down step from 0. It clears on a down step from 43690 to 43689, or when an overflow occurs.
- R8: With control bit 1 set, only the first rising edge of `latch_in` copies the count into `capture_out` and sets status bit 1. Later edges have no effect. Clearing control bit 1 clears status bit 1 and re-arms the capture.
- R9: With control bit 0 set, only the first rising edge of `enc_idx` copies the count into `capture_out` and sets status bit 0. Clearing control bit 0 clears status bit 0 and re-arms the capture.
- R10: While control bit 5 (fast mode) is set, counting still works, but preset and both captures are inactive and status bits 2..0 read 0.
- R11: After reset, the count, the capture register and the status byte are all 0.
- R12: Control bits 7, 6, 4 and 3 have no effect, and status bits 7..5 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_a | input | 1 | Encoder track A |
| enc_b | input | 1 | Encoder track B |
| enc_idx | input | 1 | Encoder reference pulse |
| gate_in | input | 1 | High freezes the count |
| latch_in | input | 1 | External capture strobe |
| ctrl_byte | input | 8 | Control byte |
| preset_val | input | 16 | Value loaded by a preset |
| count_out | output | 16 | Current position |
| capture_out | output | 16 | Last captured position |
| status_byte | output | 8 | Status flags |

## Verification
A wrong decoder or counter state shows on `count_out` one clock after the offending track sample, and the error persists through every later step. A flag that was set or cleared wrongly shows in `status_byte` in the same cycle as the step that crossed the wrap point or a threshold. It stays wrong until the opposite event occurs, so the bench walks the count across the wrap point and both thresholds in both directions. A capture arm that fails to stay spent shows on `capture_out` one clock after a second strobe edge.

// File: rtl/qenc_pkg.sv
// Shared definitions for the quadrature position counter: control and
// status bit positions and the step code passed from decoder to counter.
package qenc_pkg;
    localparam int CTL_FAST = 5;
    localparam int CTL_SET  = 2;
    localparam int CTL_EXT  = 1;
    localparam int CTL_IDX  = 0;

    localparam int ST_OVF   = 4;
    localparam int ST_UNF   = 3;
    localparam int ST_ACK   = 2;
    localparam int ST_EXT   = 1;
    localparam int ST_IDX   = 0;

    localparam int NUM_CAPT = 2;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;
endpackage

// File: rtl/qenc_step_decoder.sv
// Quadrature step decoder.
// Compares the present (A,B) sample with the previous one and reports one
// up or down step for a single-track change. A change of both tracks is
// ignored. Assumes the inputs are synchronous. The first sample after reset
// only primes the history and never produces a step.
module qenc_step_decoder
    import qenc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  trk_a,
    input  logic  trk_b,
    output step_e step
);
    logic prev_a;
    logic prev_b;
    logic primed;
    logic [3:0] pattern;

    // Keep the previous sample of both tracks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_a <= 1'b0;
            prev_b <= 1'b0;
            primed <= 1'b0;
        end else begin
            prev_a <= trk_a;
            prev_b <= trk_b;
            primed <= 1'b1;
        end
    end

    assign pattern = {prev_a, prev_b, trk_a, trk_b};

    // Classify the transition between the two samples.
    always_comb begin
        step = STEP_NONE;
        if (primed) begin
            unique case (pattern)
                4'b0010, 4'b1011, 4'b1101, 4'b0100: step = STEP_UP;
                4'b0001, 4'b0111, 4'b1110, 4'b1000: step = STEP_DOWN;
                default:                            step = STEP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/qenc_pos_counter.sv
// Position counter with preset and hysteretic wrap flags.
// A load has priority over a step and leaves the flags untouched. The
// overflow flag clears one third of the range above the wrap point. The
// underflow flag clears two thirds of the range up, that is one third
// below the wrap point.
module qenc_pos_counter
    import qenc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  step_e        step,
    input  logic         hold,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         ovf,
    output logic         unf
);
    localparam logic [W-1:0] MAXV      = {W{1'b1}};
    localparam logic [W-1:0] ONE_THIRD = MAXV / 3;
    localparam logic [W-1:0] TWO_THIRD = ONE_THIRD * 2;

    logic do_up;
    logic do_dn;

    assign do_up = !load && !hold && (step == STEP_UP);
    assign do_dn = !load && !hold && (step == STEP_DOWN);

    // Count register: a preset load, otherwise one step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (do_up) begin
            count <= count + 1'b1;
        end else if (do_dn) begin
            count <= count - 1'b1;
        end
    end

    // Wrap flags: set on a wrap, cleared by the opposite wrap or a threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
            unf <= 1'b0;
        end else if (do_up) begin
            if (count == MAXV) begin
                ovf <= 1'b1;
                unf <= 1'b0;
            end else if (count == ONE_THIRD) begin
                ovf <= 1'b0;
            end
        end else if (do_dn) begin
            if (count == '0) begin
                unf <= 1'b1;
                ovf <= 1'b0;
            end else if (count == TWO_THIRD) begin
                unf <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/qenc_capture_arm.sv
// Single-shot capture arm.
// While enabled and not yet used, the arm fires on the first rising edge of
// its trigger. It then stays spent until the enable goes low, which clears
// the valid flag and re-arms it.
module qenc_capture_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic enable,
    output logic fire,
    output logic valid
);
    logic trig_prev;

    assign fire = enable && !valid && trig && !trig_prev;

    // Track the trigger level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_prev <= 1'b0;
        else        trig_prev <= trig;
    end

    // Valid flag: set by the firing edge, cleared by dropping the enable.
    always_ff @(posedge clk) begin
        if (!rst_n)      valid <= 1'b0;
        else if (!enable) valid <= 1'b0;
        else if (fire)   valid <= 1'b1;
    end
endmodule

// File: rtl/qenc_position_unit.sv
// Quadrature position counter top level.
// Decodes the tracks, applies the gate, preset and fast-mode rules from the
// control byte, and feeds two capture arms into a shared capture register.
// Assumes all inputs are synchronous to clk.
module qenc_position_unit
    import qenc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enc_a,
    input  logic         enc_b,
    input  logic         enc_idx,
    input  logic         gate_in,
    input  logic         latch_in,
    input  logic [7:0]   ctrl_byte,
    input  logic [W-1:0] preset_val,
    output logic [W-1:0] count_out,
    output logic [W-1:0] capture_out,
    output logic [7:0]   status_byte
);
    step_e step;
    logic  fast;
    logic  set_lvl;
    logic  set_prev;
    logic  set_pulse;
    logic  set_ack;
    logic  ovf;
    logic  unf;
    logic [NUM_CAPT-1:0] cap_trig;
    logic [NUM_CAPT-1:0] cap_en;
    logic [NUM_CAPT-1:0] cap_fire;
    logic [NUM_CAPT-1:0] cap_valid;
    logic [W-1:0] cap_q;

    assign fast      = ctrl_byte[CTL_FAST];
    assign set_lvl   = ctrl_byte[CTL_SET] && !fast;
    assign set_pulse = set_lvl && !set_prev;

    qenc_step_decoder u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .trk_a (enc_a),
        .trk_b (enc_b),
        .step  (step)
    );

    qenc_pos_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .hold     (gate_in),
        .load     (set_pulse),
        .load_val (preset_val),
        .count    (count_out),
        .ovf      (ovf),
        .unf      (unf)
    );

    // Preset edge history and acknowledge flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_prev <= 1'b0;
            set_ack  <= 1'b0;
        end else begin
            set_prev <= set_lvl;
            if (!set_lvl)       set_ack <= 1'b0;
            else if (set_pulse) set_ack <= 1'b1;
        end
    end

    assign cap_trig[ST_IDX] = enc_idx;
    assign cap_trig[ST_EXT] = latch_in;
    assign cap_en[ST_IDX]   = ctrl_byte[CTL_IDX] && !fast;
    assign cap_en[ST_EXT]   = ctrl_byte[CTL_EXT] && !fast;

    for (genvar g = 0; g < NUM_CAPT; g++) begin : g_arm
        qenc_capture_arm u_arm (
            .clk    (clk),
            .rst_n  (rst_n),
            .trig   (cap_trig[g]),
            .enable (cap_en[g]),
            .fire   (cap_fire[g]),
            .valid  (cap_valid[g])
        );
    end

    // Shared capture register takes the count on any firing arm.
    always_ff @(posedge clk) begin
        if (!rst_n)         cap_q <= '0;
        else if (|cap_fire) cap_q <= count_out;
    end

    assign capture_out = cap_q;
    assign status_byte = {3'b000, ovf, unf, set_ack, cap_valid[ST_EXT], cap_valid[ST_IDX]};
endmodule

// File: rtl/qenc_position_unit_chk.sv
// Property checker for the quadrature position counter, bound to the top.
module qenc_position_unit_chk
    import qenc_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         gate_in,
    input logic [7:0]   ctrl_byte,
    input logic [W-1:0] count_out,
    input logic [W-1:0] capture_out,
    input logic [7:0]   status_byte,
    input logic         set_pulse,
    input step_e        step
);
    a_r3_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        gate_in && !set_pulse |=> $stable(count_out));

    a_r6_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_in && !set_pulse && step == STEP_UP && count_out == {W{1'b1}}
        |=> status_byte[ST_OVF] && !status_byte[ST_UNF] && count_out == '0);

    a_r7_unf_set: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_in && !set_pulse && step == STEP_DOWN && count_out == '0
        |=> status_byte[ST_UNF] && !status_byte[ST_OVF]);

    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_byte[ST_OVF] && status_byte[ST_UNF]));

    a_r8_capture_spent: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[ST_EXT] && status_byte[ST_IDX] && ctrl_byte[CTL_EXT]
        && ctrl_byte[CTL_IDX] && !ctrl_byte[CTL_FAST] |=> $stable(capture_out));

    a_r10_fast_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_byte[CTL_FAST] |=> status_byte[2:0] == 3'b000);

    a_r12_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[7:5] == 3'b000);
endmodule

bind qenc_position_unit qenc_position_unit_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gate_in     (gate_in),
    .ctrl_byte   (ctrl_byte),
    .count_out   (count_out),
    .capture_out (capture_out),
    .status_byte (status_byte),
    .set_pulse   (set_pulse),
    .step        (step)
);

// File: tb/qenc_position_unit_test.sv
`timescale 1ns/1ps
module qenc_position_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
    logic        gate_in = 1'b0, latch_in = 1'b0;
    logic [7:0]  ctrl_byte = 8'h00;
    logic [15:0] preset_val = 16'h0000;
    logic [15:0] count_out, capture_out;
    logic [7:0]  status_byte;

    int checks = 0;
    int errors = 0;

    // Bench model of the requirements.
    logic [15:0] mcnt = 0, mcap = 0;
    logic movf = 0, munf = 0, mack = 0, mext = 0, midx = 0;
    logic mset_prev = 0, mee = 0, mei = 0;
    int   ph = 0;

    always #4 clk = ~clk;

    qenc_position_unit uut (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .enc_idx(enc_idx), .gate_in(gate_in), .latch_in(latch_in),
        .ctrl_byte(ctrl_byte), .preset_val(preset_val),
        .count_out(count_out), .capture_out(capture_out),
        .status_byte(status_byte)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, "count", count_out, mcnt);
        chk(tag, "status", {8'h00, status_byte},
            {8'h00, 3'b000, movf, munf, mack, mext, midx});
        chk(tag, "capture", capture_out, mcap);
    endtask

    // Track phase order 00,10,11,01 for A leading B.
    function automatic logic [1:0] phase_ab(int p);
        case (p & 3)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    function automatic void model_step(int dir);
        if (gate_in) return;
        if (dir > 0) begin
            if (mcnt == 16'hFFFF) begin movf = 1; munf = 0; end
            else if (mcnt == 16'd21845) movf = 0;
            mcnt = mcnt + 1;
        end else begin
            if (mcnt == 16'h0000) begin munf = 1; movf = 0; end
            else if (mcnt == 16'd43690) munf = 0;
            mcnt = mcnt - 1;
        end
    endfunction

    task automatic move(int dir);
        ph = ph + dir;
        {enc_a, enc_b} = phase_ab(ph);
        tick();
        model_step(dir);
    endtask

    task automatic jump_both();
        ph = ph + 2;
        {enc_a, enc_b} = phase_ab(ph);
        tick();
    endtask

    task automatic set_ctrl(logic [7:0] v);
        logic f, es;
        ctrl_byte = v;
        tick();
        f  = v[5];
        es = v[2] && !f;
        if (es && !mset_prev) begin mcnt = preset_val; mack = 1; end
        if (!es) mack = 0;
        mset_prev = es;
        mee = v[1] && !f;
        mei = v[0] && !f;
        if (!mee) mext = 0;
        if (!mei) midx = 0;
    endtask

    task automatic preset_to(logic [15:0] v);
        preset_val = v;
        set_ctrl(8'h04);
        set_ctrl(8'h00);
    endtask

    task automatic pulse_latch(string tag);
        latch_in = 1'b1;
        tick();
        if (mee && !mext) begin mcap = mcnt; mext = 1; end
        check_all(tag);
        latch_in = 1'b0;
        tick();
    endtask

    task automatic pulse_index(string tag);
        enc_idx = 1'b1;
        tick();
        if (mei && !midx) begin mcap = mcnt; midx = 1; end
        check_all(tag);
        enc_idx = 1'b0;
        tick();
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check_all("R11");

        // R1: up and down steps
        for (int i = 0; i < 6; i++) move(1);
        check_all("R1");
        for (int i = 0; i < 2; i++) move(-1);
        check_all("R1");

        // R2: both tracks change together
        jump_both();
        check_all("R2");
        move(1);
        check_all("R2");

        // R3: gate freezes counting
        gate_in = 1'b1;
        for (int i = 0; i < 3; i++) move(1);
        check_all("R3");
        gate_in = 1'b0;
        move(-1);
        check_all("R3");

        // R4 and R7: downward wrap through zero
        preset_to(16'd1);
        move(-1);
        move(-1);
        check_all("R4");

        // R5: preset on rising edge only, acknowledge follows control bit
        preset_val = 16'd65534;
        set_ctrl(8'h04);
        check_all("R5");
        preset_val = 16'd5;
        tick();
        check_all("R5");
        set_ctrl(8'h00);
        check_all("R5");

        // R6: overflow sets on wrap and clears the underflow
        move(1);
        move(1);
        check_all("R6");
        preset_to(16'd21844);
        move(1);
        check_all("R6");
        move(1);
        check_all("R6");

        // R7: underflow threshold
        preset_to(16'd0);
        move(-1);
        check_all("R7");
        preset_to(16'd43691);
        move(-1);
        check_all("R7");
        move(-1);
        check_all("R7");

        // R8: external capture, single shot, re-arm
        set_ctrl(8'h02);
        pulse_latch("R8");
        move(1);
        pulse_latch("R8");
        set_ctrl(8'h00);
        check_all("R8");
        set_ctrl(8'h02);
        pulse_latch("R8");

        // R9: index capture
        set_ctrl(8'h01);
        move(1);
        pulse_index("R9");
        move(1);
        pulse_index("R9");
        set_ctrl(8'h00);
        check_all("R9");

        // R10: fast mode ignores preset and captures but keeps counting
        preset_val = 16'd777;
        set_ctrl(8'h20);
        set_ctrl(8'h27);
        check_all("R10");
        pulse_latch("R10");
        pulse_index("R10");
        move(1);
        check_all("R10");
        set_ctrl(8'h00);

        // R12: unused control bits have no effect
        set_ctrl(8'hD8);
        pulse_latch("R12");
        move(-1);
        check_all("R12");
        set_ctrl(8'h00);

        // Random walk around the wrap point (R1 R2 R3 R4 R6 R7)
        preset_to(16'd65530);
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom % 10;
            if (r < 4)       move(1);
            else if (r < 8)  move(-1);
            else if (r == 8) begin gate_in = ~gate_in; tick(); end
            else             jump_both();
            chk("R1", "random count", count_out, mcnt);
            chk("R6", "random flags", {14'h0, status_byte[4:3]}, {14'h0, movf, munf});
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule